// File: doc/BRIEF.md
# Heron Square-Root Table Sequencer

This block takes a table of unsigned fixed-point words in an external word-addressed RAM and overwrites each entry with its square root. The root comes from Heron's iteration, x <- (x + S/x)/2, which runs on the raw integer value of each word. A control sequencer drives a datapath through a small set of strobes. The datapath holds the working registers, a single subtracting ALU that captures carry (borrow) and zero flags, and a restoring divider that takes one bit per cycle.

The block is used as follows. Software writes the operand count to address 0 and the operands to addresses 1 through that count, then pulses `start`. The sequencer works through the table from the highest address down to address 1 and writes each result back to the word it came from. When the table is finished it raises `ready` and holds it high until the next start. Reads are combinational: the sequencer drives the address and the read enable in one cycle, registers the returned word, and uses that word in the following cycle.

Top module: `heron_sqrt_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `ready`, `ramRdEn` and `ramWrEn` are all low.
- R2: The operand count is read from address 0 and is never written. A count of zero raises `ready` with no write at all.
- R3: For a count N, exactly N writes occur, at addresses N, N-1, …, 1 in that order. Each write goes to the address from which its operand was read.
- R4: An operand whose raw value is 0 or 1 is written back unchanged.
- R5: For a raw operand S of 2 or more, let x = S>>1. Repeat x' = (x + floor(S/x))>>1. Continue while x' < x, using x' as the next x. At the first x' that is not less than x, the value written is x' << (FRAC_W/2), truncated to DATA_W bits.
- R6: `ready` goes low in the cycle after `start` is sampled. It stays low until the table is done, then stays high, with both RAM enables low, until the next start. A `start` pulse during a run is ignored: the run still completes with correct results and exactly N writes.
- R7: `ramRdEn` and `ramWrEn` are never high together, and `ramWrData` is all zeros whenever `ramWrEn` is low.
- R8: A `start` pulse after `ready` has risen processes the table currently in RAM from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin processing the table; sampled when idle or done |
| ready | output | 1 | High once the table has been processed |
| ramAddr | output | ADDR_W (10) | Word address to the RAM |
| ramRdEn | output | 1 | Read enable; the RAM returns data in the same cycle |
| ramWrEn | output | 1 | Write enable; the RAM writes on the rising edge |
| ramRdData | input | DATA_W (32) | Read data from the RAM |
| ramWrData | output | DATA_W (32) | Write data, zero when not writing |

## Verification
The hardest behaviour to reach from the ports is a long convergence run. For near-full-scale operands the estimate starts at S/2 and takes many divide passes. The stop condition then has to catch the point where the sequence steps back up by one, instead of stopping too early or looping forever. The stimulus sweeps every raw value from 0 to 199 and adds a table of near-full-scale and perfect-square operands. A reference model in the bench runs the same integer recurrence. A second `start` pulse is injected while the long table is still running, which shows that mid-run requests leave both the address order and the results unchanged.

// File: rtl/heron_pkg.sv
package heron_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_RDN1, ST_RDN2, ST_CHKI, ST_RDS1, ST_RDS2, ST_CHKS,
    ST_XINIT, ST_DIVGO, ST_DIVWAIT, ST_SUM, ST_CMP, ST_BRANCH,
    ST_WRRAW, ST_WRROOT, ST_DEC, ST_DONE
  } seqState_t;

  // datapath strobes issued by the sequencer
  typedef struct packed {
    logic ldN;    // count word -> index, zero flag
    logic chkS;   // operand word -> S, flags of S-1
    logic initX;  // X and OLD_X <- S>>1
    logic divGo;  // start S/X
    logic ldSum;  // X <- (X + quotient)>>1
    logic cmp;    // flags of X - OLD_X
    logic ldOld;  // OLD_X <- X
    logic decI;   // index - 1, zero flag
  } strobe_t;

endpackage

// File: rtl/heron_div.sv
module heron_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remReg, quoReg, dvsReg, dvdReg;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    trial;
  logic          fits;

  assign trial    = {remReg, quoReg[W-1]};
  assign fits     = trial >= {1'b0, dvsReg};
  assign quotient = quoReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      remReg <= '0;
      quoReg <= '0;
      dvsReg <= '0;
      dvdReg <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else if (go) begin
      remReg <= '0;
      quoReg <= dividend;
      dvsReg <= divisor;
      dvdReg <= dividend;
      cnt    <= CW'(W);
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      remReg <= fits ? W'(trial - {1'b0, dvsReg}) : trial[W-1:0];
      quoReg <= {quoReg[W-2:0], fits};
      cnt    <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  logic [2*W-1:0] prodChk;
  assign prodChk = {{W{1'b0}}, quoReg} * {{W{1'b0}}, dvsReg};

  // R5
  div_result_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (prodChk <= {{W{1'b0}}, dvdReg}) &&
                    (({{W{1'b0}}, dvdReg} - prodChk) < {{W{1'b0}}, dvsReg}));

endmodule

// File: rtl/heron_dp.sv
module heron_dp
  import heron_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic              latchDin,
  input  logic [DATA_W-1:0] rdData,
  output logic              flagC,
  output logic              flagZ,
  output logic              divDone,
  output logic [ADDR_W-1:0] idx,
  output logic [DATA_W-1:0] sVal,
  output logic [DATA_W-1:0] xVal
);
  logic [DATA_W-1:0] dinReg, sReg, xReg, oldReg, quot;
  logic [ADDR_W-1:0] idxReg;
  logic [DATA_W-1:0] opA, opB;
  logic [DATA_W:0]   aluRes;
  logic              setFlags;

  heron_div #(.W(DATA_W)) div_i (
    .clk(clk), .rst(rst), .go(st.divGo),
    .dividend(sReg), .divisor(xReg),
    .quotient(quot), .done(divDone)
  );

  always_comb begin
    opA = '0;
    opB = '0;
    if (st.ldN) begin
      opA = DATA_W'(dinReg[ADDR_W-1:0]);
    end else if (st.chkS) begin
      opA = dinReg;
      opB = DATA_W'(1);
    end else if (st.cmp) begin
      opA = xReg;
      opB = oldReg;
    end else if (st.decI) begin
      opA = DATA_W'(idxReg);
      opB = DATA_W'(1);
    end
  end

  assign aluRes   = {1'b0, opA} - {1'b0, opB};
  assign setFlags = st.ldN | st.chkS | st.cmp | st.decI;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dinReg <= '0;
      sReg   <= '0;
      xReg   <= '0;
      oldReg <= '0;
      idxReg <= '0;
      flagC  <= 1'b0;
      flagZ  <= 1'b0;
    end else begin
      if (latchDin) dinReg <= rdData;
      if (st.ldN)   idxReg <= dinReg[ADDR_W-1:0];
      if (st.decI)  idxReg <= aluRes[ADDR_W-1:0];
      if (st.chkS)  sReg   <= dinReg;
      if (st.initX) begin
        xReg   <= sReg >> 1;
        oldReg <= sReg >> 1;
      end
      if (st.ldSum) xReg   <= DATA_W'(({1'b0, xReg} + {1'b0, quot}) >> 1);
      if (st.ldOld) oldReg <= xReg;
      if (setFlags) begin
        flagC <= aluRes[DATA_W];
        flagZ <= (aluRes[DATA_W-1:0] == '0);
      end
    end
  end

  assign idx  = idxReg;
  assign sVal = sReg;
  assign xVal = xReg;

  // R5
  div_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    st.divGo |-> (xReg != '0));
  // R5
  converge_chk: assert property (@(posedge clk) disable iff (rst)
    st.ldOld |-> (xReg < oldReg));
  // R3
  idx_dec_chk: assert property (@(posedge clk) disable iff (rst)
    st.decI |=> (idxReg == $past(idxReg) - 1'b1));

endmodule

// File: rtl/heron_ctrl.sv
module heron_ctrl
  import heron_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    flagC,
  input  logic    flagZ,
  input  logic    divDone,
  output strobe_t st,
  output logic    rdEn,
  output logic    wrEn,
  output logic    wrRaw,
  output logic    useIdx,
  output logic    ready
);
  seqState_t state, nextState;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    st        = '0;
    rdEn      = 1'b0;
    wrEn      = 1'b0;
    wrRaw     = 1'b0;
    useIdx    = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: if (start) nextState = ST_RDN1;
      ST_RDN1: begin
        rdEn = 1'b1;
        nextState = ST_RDN2;
      end
      ST_RDN2: begin
        st.ldN = 1'b1;
        nextState = ST_CHKI;
      end
      ST_CHKI: nextState = flagZ ? ST_DONE : ST_RDS1;
      ST_RDS1: begin
        rdEn = 1'b1;
        useIdx = 1'b1;
        nextState = ST_RDS2;
      end
      ST_RDS2: begin
        st.chkS = 1'b1;
        nextState = ST_CHKS;
      end
      ST_CHKS: nextState = (flagC | flagZ) ? ST_WRRAW : ST_XINIT;
      ST_XINIT: begin
        st.initX = 1'b1;
        nextState = ST_DIVGO;
      end
      ST_DIVGO: begin
        st.divGo = 1'b1;
        nextState = ST_DIVWAIT;
      end
      ST_DIVWAIT: if (divDone) nextState = ST_SUM;
      ST_SUM: begin
        st.ldSum = 1'b1;
        nextState = ST_CMP;
      end
      ST_CMP: begin
        st.cmp = 1'b1;
        nextState = ST_BRANCH;
      end
      ST_BRANCH: begin
        if (flagC) begin
          st.ldOld = 1'b1;
          nextState = ST_DIVGO;
        end else begin
          nextState = ST_WRROOT;
        end
      end
      ST_WRRAW: begin
        wrEn = 1'b1;
        wrRaw = 1'b1;
        useIdx = 1'b1;
        nextState = ST_DEC;
      end
      ST_WRROOT: begin
        wrEn = 1'b1;
        useIdx = 1'b1;
        nextState = ST_DEC;
      end
      ST_DEC: begin
        st.decI = 1'b1;
        nextState = ST_CHKI;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign ready = (state == ST_DONE);

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rdEn && wrEn));
  // R6
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!rdEn && !wrEn));
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready);

endmodule

// File: rtl/heron_sqrt_seq.sv
module heron_sqrt_seq
  import heron_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              ready,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] ramWrData
);
  localparam int HALF_FRAC = FRAC_W / 2;

  strobe_t           st;
  logic              wrRaw, useIdx, flagC, flagZ, divDone;
  logic [ADDR_W-1:0] idx;
  logic [DATA_W-1:0] sVal, xVal;

  heron_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .flagC(flagC), .flagZ(flagZ), .divDone(divDone),
    .st(st), .rdEn(ramRdEn), .wrEn(ramWrEn),
    .wrRaw(wrRaw), .useIdx(useIdx), .ready(ready)
  );

  heron_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst(rst), .st(st), .latchDin(ramRdEn),
    .rdData(ramRdData), .flagC(flagC), .flagZ(flagZ),
    .divDone(divDone), .idx(idx), .sVal(sVal), .xVal(xVal)
  );

  assign ramAddr   = useIdx ? idx : '0;
  assign ramWrData = !ramWrEn ? '0 : (wrRaw ? sVal : (xVal << HALF_FRAC));

  // R2
  count_word_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ramWrEn |-> (ramAddr != '0));

endmodule

// File: tb/heron_sqrt_seq_tb_top.sv
module heron_sqrt_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ready, ramRdEn, ramWrEn;
  logic [9:0]  ramAddr;
  logic [31:0] ramRdData, ramWrData;

  logic [31:0] mem [0:1023];
  logic [31:0] golden [0:1023];

  int checks = 0, fails = 0, cycles = 0;
  int expAddr = 0, writes = 0, orderBad = 0, busBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  heron_sqrt_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .ready(ready),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramWrEn(ramWrEn),
    .ramRdData(ramRdData), .ramWrData(ramWrData)
  );

  assign ramRdData = ramRdEn ? mem[ramAddr] : 32'h0;

  always @(posedge clk) if (ramWrEn) mem[ramAddr] <= ramWrData;

  // bus monitor (R2, R3, R6, R7)
  always @(negedge clk) begin
    if (!rst) begin
      if (ramRdEn && ramWrEn) busBad++;
      if (!ramWrEn && ramWrData != 0) busBad++;
      if (ready && (ramRdEn || ramWrEn)) busBad++;
      if (ramWrEn) begin
        if (int'(ramAddr) != expAddr) orderBad++;
        expAddr--;
        writes++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRoot(input logic [31:0] s);
    logic [31:0] x, q, xn;
    if (s < 2) return s;
    x = s >> 1;
    forever begin
      q  = s / x;
      xn = 32'(({1'b0, x} + {1'b0, q}) >> 1);
      if (xn < x) x = xn;
      else return xn << 4;
    end
  endfunction

  task automatic runTable(input int n, input bit poke);
    int waitCnt;
    for (int k = 1; k <= n; k++) golden[k] = expRoot(mem[k]);
    expAddr = n;
    writes = 0;
    orderBad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(ready == 1'b0, "R6 ready low after start", 32'(ready), 32'h0);
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    waitCnt = 0;
    while (!ready && waitCnt < 150000) begin
      @(negedge clk);
      waitCnt++;
    end
    chk(ready == 1'b1, "R6 ready after table", 32'(ready), 32'h1);
    for (int k = 1; k <= n; k++) begin
      if (golden[k] == mem[k] || 1'b1) begin
        if (k <= n) begin
          if (golden[k] < 2)
            chk(mem[k] == golden[k], "R4 small operand kept", mem[k], golden[k]);
          else
            chk(mem[k] == golden[k], "R5 root value", mem[k], golden[k]);
        end
      end
    end
    chk(writes == n, "R3 write count", 32'(writes), 32'(n));
    chk(orderBad == 0, "R3 write order", 32'(orderBad), 32'h0);
    chk(mem[0] == 32'(n), "R2 count word untouched", mem[0], 32'(n));
    repeat (5) @(negedge clk);
    chk(ready == 1'b1, "R6 ready held", 32'(ready), 32'h1);
    chk(busBad == 0, "R7 bus rules", 32'(busBad), 32'h0);
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0 && !ramRdEn && !ramWrEn, "R1 reset outputs", {ready, ramRdEn, ramWrEn}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0 && !ramRdEn && !ramWrEn, "R1 after release", {ready, ramRdEn, ramWrEn}, 32'h0);

    // R2: empty table
    mem[0] = 32'd0;
    runTable(0, 1'b0);

    // R4 R5: sweep of small raw values
    mem[0] = 32'd200;
    for (int k = 1; k <= 200; k++) mem[k] = 32'(k - 1);
    runTable(200, 1'b0);

    // R5 R6: wide operands with a stray start during the run
    mem[0] = 32'd8;
    mem[1] = 32'hFFFF_FFFF;
    mem[2] = 32'h8000_0000;
    mem[3] = 32'd1 << 8;
    mem[4] = 32'd4 << 8;
    mem[5] = 32'd2 << 8;
    mem[6] = 32'h1234_5678;
    mem[7] = 32'd65535 * 32'd65535;
    mem[8] = 32'd16 << 8;
    runTable(8, 1'b1);

    // R8: restart after done
    mem[0] = 32'd5;
    for (int k = 1; k <= 5; k++) mem[k] = 32'(k * 997 + 3);
    runTable(5, 1'b0);

    summary();
  end

endmodule